// File: doc/BRIEF.md
# Receive Link Fault and Transition Monitor

This block sits beside one receive channel and decides whether the link is healthy. It looks at the stream of recovered 10-bit characters for long stretches without a bit change. It counts how many characters arrive in a fixed window of reference clocks, which checks the received data rate. It merges these two results with three status flags from analog and PLL logic outside the block. The result is a single active-low link-fault output.

When monitoring is enabled, any failure among the digital detectors or the amplitude flag also raises a lock-source select. That select tells the receive PLL to follow the reference clock instead of the incoming serial data.

Characters arrive on a valid/ready stream. The monitor never applies back-pressure: ready is low only while reset is held, and every character presented with valid high while ready is high is consumed in that cycle. The monitor, rate programming and flag pins are plain level signals.

Top module: `link_fault_monitor`

## Requirements
- R1: `chr_ready` is low while `rst_n` is low and high on every cycle after the first clock edge with `rst_n` high. A character is consumed on each rising edge where `chr_valid` and `chr_ready` are both high.
- R2: Bits of a character are taken in time order from bit 0 (earliest) to bit 9 (latest). The count of identical consecutive bits continues across character boundaries. The bit before the first character after reset counts as 0.
- R3: The density fault is set when a consumed character brings the run of identical bits above RUN_LIMIT (60) bits. It is cleared by a consumed character that leaves the run at or below RUN_LIMIT. `link_fault_n` shows the change two rising edges after the character is consumed.
- R4: Every WINDOW_CYC clocks, the number of characters consumed in that window is compared with the range from `rate_expect - rate_tol` (floored at 0) to `rate_expect + rate_tol`, both ends inclusive. A count outside this range sets the rate fault, and a count inside clears it. The result holds until the next window closes.
- R5: `link_fault_n` is low exactly when any of five conditions holds: density fault, rate fault, `amp_low`, `pll_unlock` or `rx_pd`. It is registered, so a flag input change shows one rising edge later.
- R6: `lock_to_ref` is high exactly when `mon_en` is high and at least one of density fault, rate fault or `amp_low` holds. It is registered like `link_fault_n`. `pll_unlock` and `rx_pd` never affect it.
- R7: With `mon_en` low, `lock_to_ref` stays low while every detector fault still drives `link_fault_n` low.
- R8: After reset, `link_fault_n` is high, `lock_to_ref` is low and both internal detector faults are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_valid | input | 1 | Recovered character present |
| chr_ready | output | 1 | Monitor accepts characters (high outside reset) |
| chr_data | input | CHAR_W | Recovered character, bit 0 first in time |
| mon_en | input | 1 | Lets detector faults steer the lock source |
| amp_low | input | 1 | Analog amplitude below threshold |
| pll_unlock | input | 1 | Receive PLL lost lock |
| rx_pd | input | 1 | Receive path powered down |
| rate_expect | input | CW | Expected characters per window |
| rate_tol | input | CW | Allowed deviation in characters per window |
| link_fault_n | output | 1 | Active-low merged link fault |
| lock_to_ref | output | 1 | Receive PLL should track the reference clock |

## Verification
The run-length sweep places a single 1 at each bit position and follows it with zero characters. This puts the run exactly at 60 and at 61 bits. A design that cleared the run at character boundaries, used the wrong bit order or compared with >= instead of > would flag one character early or never. The rate sweep walks every per-window count from empty to full, against both a centred range and a range whose lower end would underflow. An off-by-one at either inclusive edge, or a wrapped lower bound, shows up as a wrong fault. All eight flag combinations are applied with monitoring on and off, with and without a density fault. This catches a lock select that wrongly reacts to PLL loss or power-down, or a fault path that is wrongly masked by the enable.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
  typedef struct packed {
    logic density;
    logic rate;
    logic amp;
    logic unlock;
    logic pdown;
  } fault_vec_t;

  function automatic logic any_fault(fault_vec_t f);
    return f.density | f.rate | f.amp | f.unlock | f.pdown;
  endfunction

  function automatic logic steer_fault(fault_vec_t f);
    return f.density | f.rate | f.amp;
  endfunction
endpackage

// File: rtl/lfm_run_detect.sv
module lfm_run_detect #(
  parameter int CHAR_W    = 10,
  parameter int RUN_LIMIT = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CHAR_W-1:0] bits_in,
  output logic              sparse
);
  localparam int RUN_W = $clog2(RUN_LIMIT + 2);

  logic [RUN_W-1:0] run_q, run_d;
  logic             last_q, last_d;
  logic             sparse_q;

  always_comb begin
    run_d  = run_q;
    last_d = last_q;
    for (int i = 0; i < CHAR_W; i++) begin
      if (bits_in[i] != last_d) begin
        run_d = RUN_W'(1);
      end else if (run_d <= RUN_W'(RUN_LIMIT)) begin
        run_d = run_d + RUN_W'(1);
      end
      last_d = bits_in[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      last_q   <= 1'b0;
      sparse_q <= 1'b0;
    end else if (take) begin
      run_q    <= run_d;
      last_q   <= last_d;
      sparse_q <= (run_d > RUN_W'(RUN_LIMIT));
    end
  end

  assign sparse = sparse_q;
endmodule

// File: rtl/lfm_rate_window.sv
module lfm_rate_window #(
  parameter int WINDOW_CYC = 1024,
  parameter int CW         = $clog2(WINDOW_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [CW-1:0] expect_cnt,
  input  logic [CW-1:0] tol_cnt,
  output logic          off_rate
);
  localparam int WW = (WINDOW_CYC > 2) ? $clog2(WINDOW_CYC) : 1;

  logic [WW-1:0] win_q;
  logic [CW-1:0] cnt_q;
  logic          off_q;
  logic          win_end;
  logic [CW:0]   total, lo_bound, hi_bound;

  assign win_end  = (win_q == WW'(WINDOW_CYC - 1));
  assign total    = {1'b0, cnt_q} + (CW+1)'(take);
  assign hi_bound = {1'b0, expect_cnt} + {1'b0, tol_cnt};
  assign lo_bound = (expect_cnt >= tol_cnt) ? {1'b0, expect_cnt - tol_cnt} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
      off_q <= 1'b0;
    end else if (win_end) begin
      win_q <= '0;
      cnt_q <= '0;
      off_q <= (total < lo_bound) || (total > hi_bound);
    end else begin
      win_q <= win_q + WW'(1);
      cnt_q <= total[CW-1:0];
    end
  end

  assign off_rate = off_q;
endmodule

// File: rtl/lfm_fault_merge.sv
module lfm_fault_merge
  import lfm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mon_en,
  input  fault_vec_t faults,
  output logic       fault_n,
  output logic       use_ref
);
  logic fault_n_q, use_ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_n_q <= 1'b1;
      use_ref_q <= 1'b0;
    end else begin
      fault_n_q <= ~any_fault(faults);
      use_ref_q <= mon_en & steer_fault(faults);
    end
  end

  assign fault_n = fault_n_q;
  assign use_ref = use_ref_q;
endmodule

// File: rtl/link_fault_monitor.sv
module link_fault_monitor
  import lfm_pkg::*;
#(
  parameter int CHAR_W     = 10,
  parameter int RUN_LIMIT  = 60,
  parameter int WINDOW_CYC = 1024,
  parameter int CW         = $clog2(WINDOW_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chr_valid,
  output logic              chr_ready,
  input  logic [CHAR_W-1:0] chr_data,
  input  logic              mon_en,
  input  logic              amp_low,
  input  logic              pll_unlock,
  input  logic              rx_pd,
  input  logic [CW-1:0]     rate_expect,
  input  logic [CW-1:0]     rate_tol,
  output logic              link_fault_n,
  output logic              lock_to_ref
);
  logic       ready_q;
  logic       take;
  logic       tdens_fault;
  logic       rate_fault;
  fault_vec_t fv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign chr_ready = ready_q;
  assign take      = chr_valid & ready_q;

  lfm_run_detect #(.CHAR_W(CHAR_W), .RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .bits_in (chr_data),
    .sparse  (tdens_fault)
  );

  lfm_rate_window #(.WINDOW_CYC(WINDOW_CYC), .CW(CW)) u_rate (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .expect_cnt (rate_expect),
    .tol_cnt    (rate_tol),
    .off_rate   (rate_fault)
  );

  always_comb begin
    fv.density = tdens_fault;
    fv.rate    = rate_fault;
    fv.amp     = amp_low;
    fv.unlock  = pll_unlock;
    fv.pdown   = rx_pd;
  end

  lfm_fault_merge u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .mon_en  (mon_en),
    .faults  (fv),
    .fault_n (link_fault_n),
    .use_ref (lock_to_ref)
  );
endmodule

// File: rtl/lfm_checker.sv
module lfm_checker #(
  parameter int CHAR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chr_valid,
  input logic              chr_ready,
  input logic [CHAR_W-1:0] chr_data,
  input logic              mon_en,
  input logic              amp_low,
  input logic              pll_unlock,
  input logic              rx_pd,
  input logic              tdens_fault,
  input logic              link_fault_n,
  input logic              lock_to_ref
);
  AST_READY_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    chr_ready |=> chr_ready); // R1

  AST_MIXED_CHAR_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && chr_ready && chr_data != '0 && chr_data != '1) |=> !tdens_fault); // R3

  AST_POWERDOWN_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pd |=> !link_fault_n); // R5

  AST_UNLOCK_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    pll_unlock |=> !link_fault_n); // R5

  AST_AMP_STEERS: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_low && mon_en) |=> lock_to_ref); // R6

  AST_LOCK_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    lock_to_ref |-> !link_fault_n); // R6

  AST_DISABLED_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> !lock_to_ref); // R7
endmodule

bind link_fault_monitor lfm_checker #(.CHAR_W(CHAR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .chr_valid    (chr_valid),
  .chr_ready    (chr_ready),
  .chr_data     (chr_data),
  .mon_en       (mon_en),
  .amp_low      (amp_low),
  .pll_unlock   (pll_unlock),
  .rx_pd        (rx_pd),
  .tdens_fault  (tdens_fault),
  .link_fault_n (link_fault_n),
  .lock_to_ref  (lock_to_ref)
);

// File: tb/link_fault_monitor_test.sv
module link_fault_monitor_test;
  localparam int WIN = 16;
  localparam int CWT = $clog2(WIN + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           chr_valid = 1'b0;
  logic           chr_ready;
  logic [9:0]     chr_data = '0;
  logic           mon_en = 1'b1;
  logic           amp_low = 1'b0, pll_unlock = 1'b0, rx_pd = 1'b0;
  logic [CWT-1:0] rate_expect = CWT'(8);
  logic [CWT-1:0] rate_tol = CWT'(15);
  logic           link_fault_n, lock_to_ref;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  int m_run = 0;
  bit m_last = 0;
  bit m_dens = 0;

  always #4 clk = ~clk;

  link_fault_monitor #(.CHAR_W(10), .RUN_LIMIT(60), .WINDOW_CYC(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_ready(chr_ready),
    .chr_data(chr_data), .mon_en(mon_en), .amp_low(amp_low),
    .pll_unlock(pll_unlock), .rx_pd(rx_pd), .rate_expect(rate_expect),
    .rate_tol(rate_tol), .link_fault_n(link_fault_n), .lock_to_ref(lock_to_ref)
  );

  task automatic check(string req, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_char(logic [9:0] d);
    for (int i = 0; i < 10; i++) begin
      if (d[i] != m_last) m_run = 1;
      else m_run++;
      m_last = d[i];
    end
    m_dens = (m_run > 60);
  endtask

  // at negedge on entry and exit
  task automatic send_char(logic [9:0] d);
    chr_valid = 1'b1;
    chr_data  = d;
    @(posedge clk);
    @(negedge clk);
    chr_valid = 1'b0;
    model_char(d);
    @(posedge clk);
    @(negedge clk);
    check("R3 density fault", link_fault_n, ~m_dens);
    check("R6 density steer", lock_to_ref, mon_en & m_dens);
  endtask

  task automatic flag_sweep();
    for (int f = 0; f < 8; f++) begin
      amp_low    = f[0];
      pll_unlock = f[1];
      rx_pd      = f[2];
      @(posedge clk);
      @(negedge clk);
      check("R5 merged fault", link_fault_n, ~(f[0] | f[1] | f[2] | m_dens));
      check(mon_en ? "R6 lock select" : "R7 masked lock", lock_to_ref,
            mon_en & (f[0] | m_dens));
    end
    amp_low = 0; pll_unlock = 0; rx_pd = 0;
  endtask

  task automatic rate_case(int m, int ex, int tol);
    int lo, hi;
    bit exp_f;
    rate_expect = CWT'(ex);
    rate_tol    = CWT'(tol);
    for (int c = 0; c < 3 * WIN; c++) begin
      chr_valid = ((c % WIN) < m);
      chr_data  = 10'h155;
      @(posedge clk);
      @(negedge clk);
    end
    chr_valid = 1'b0;
    lo = (ex >= tol) ? ex - tol : 0;
    hi = ex + tol;
    exp_f = (m < lo) || (m > hi);
    check("R4 rate window", link_fault_n, ~exp_f);
    check("R6 rate steer", lock_to_ref, exp_f);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 ready in reset", chr_ready, 1'b0);
    check("R8 reset fault", link_fault_n, 1'b1);
    check("R8 reset lock", lock_to_ref, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 ready after reset", chr_ready, 1'b1);
    check("R8 idle fault", link_fault_n, 1'b1);

    // R2 R3: one-hot position sweep around the 60/61-bit boundary
    for (int k = 0; k < 10; k++) begin
      send_char(10'h2AA);
      send_char(10'(1 << k));
      for (int z = 0; z < 7; z++) send_char(10'h000);
    end
    send_char(10'h000);
    for (int z = 0; z < 7; z++) send_char(10'h3FF);
    send_char(10'h3FE);

    // R5 R6 R7: flags with and without density fault, enable on and off
    send_char(10'h155);
    for (int e = 0; e < 2; e++) begin
      mon_en = e[0];
      @(posedge clk); @(negedge clk);
      flag_sweep();
    end
    for (int z = 0; z < 7; z++) send_char(10'h000);
    check("R3 fault before sweep", link_fault_n, 1'b0);
    for (int e = 0; e < 2; e++) begin
      mon_en = e[0];
      @(posedge clk); @(negedge clk);
      flag_sweep();
    end
    send_char(10'h155);

    // R4: every per-window count against two ranges
    mon_en = 1'b1;
    for (int m = 0; m <= WIN; m++) rate_case(m, 8, 2);
    for (int m = 0; m <= 7; m++) rate_case(m, 2, 3);
    rate_case(0, 8, 15);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule